// File: doc/BRIEF.md
# Coincident-Current Core Store Cycle Sequencer

This block runs one access of a magnetic core store that holds 8192 words of 18 bits: 16 data bits and two parity bits, one per byte. Reading a core is destructive. Each cycle therefore has two halves. The read half drives the addressed X and Y lines toward zero and samples one sense input per bit plane. The write half drives the same lines toward one and puts back a word. For each plane whose bit must stay 0, it asserts inhibit on the single sense/inhibit segment that holds the address.

A cycle begins with a one-clock `start` pulse. `cyc_store` selects the cycle type. A display (read) cycle writes the sensed word back unchanged. A store cycle replaces the word with `wr_data` and freshly computed parity. The data register then holds the resulting word. Parity of the sensed word is checked between the two halves, and a mismatch raises a flag.

The phase machine has five states. IDLE waits for a start. READ runs four drive clocks, with the strobe on the third. GAP is one clock with no drive. WRITE runs four drive clocks. DONE lasts one clock and then returns to IDLE. The transitions are start-accepted (IDLE to READ), read-count-expired (READ to GAP), gap-expired (GAP to WRITE), write-count-expired (WRITE to DONE) and always (DONE to IDLE).

Top module: `core_cycle_seq`

## Requirements
- R1: After reset, the block is idle. Drive enable, strobe, all inhibit bits, done, busy, the data register and the parity-error flag are all 0.
- R2: For the address captured at start, `x_line` equals address bits [5:0] and `y_line` equals address bits [12:6]. The segment is address bits [12:11].
- R3: The read half begins in the clock after the start is accepted. It lasts 4 clocks with `drive_en`=1 and `drive_dir`=0 (toward zero).
- R4: `sense_strobe` is high for exactly one clock, the third clock of the read half. Each plane whose sense input is 1 at that clock has its data register bit set to 1. Every other bit reads 0, because the register is cleared at start.
- R5: Exactly one clock with `drive_en`=0 separates the read half from the write half.
- R6: The write half lasts 4 clocks with `drive_en`=1 and `drive_dir`=1. Inhibit bit index p*4+s is high on all 4 clocks when plane p has data register bit 0 and s is the address segment. Inhibit bits of the other segments stay 0.
- R7: No inhibit bit is ever high outside the write half.
- R8: A display cycle writes back the sensed word unchanged, including parity bits that are wrong.
- R9: A store cycle writes {p17, p16, wr_data}. Bit 16 makes data[7:0] plus itself odd, and bit 17 does the same for data[15:8]. The data register shows this word after the cycle.
- R10: `parity_err` is set when the sensed word fails the odd-per-byte check. It clears when the next start is accepted and holds in between.
- R11: `done` is high for exactly one clock, directly after the write half. The next clock is idle.
- R12: A start that arrives while busy is ignored. The running cycle keeps its address and timing, and no extra cycle follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a cycle (one clock) |
| cyc_store | input | 1 | 1 = store cycle, 0 = display cycle |
| addr | input | 13 | Word address |
| wr_data | input | 16 | Data for store cycles |
| sense | input | 18 | Sense amplifier output per plane |
| x_line | output | 6 | Selected X drive line |
| y_line | output | 7 | Selected Y drive line |
| drive_en | output | 1 | X/Y drive current on |
| drive_dir | output | 1 | 0 = toward zero, 1 = toward one |
| sense_strobe | output | 1 | Sense sampling window |
| inhibit | output | 72 | Inhibit enable, index plane*4+segment |
| data_reg | output | 18 | Data register (parity in bits 17:16) |
| parity_err | output | 1 | Sensed word failed parity |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | Cycle complete (one clock) |

## Verification
The parity check of the sensed word and the load of new store data happen on the same clock, the last GAP clock. The bench provokes this with store cycles over words whose parity is wrong: never-written cores that read all zeros, and a core bit corrupted in the behavioural array. It then expects `parity_err`=1 while `data_reg` already holds the new word with correct parity. A second overlap is a start pulse raised during a running read half. The bench judges it by the unchanged phase timing and line selects, and by an idle clock after done.

// File: rtl/core_seq_pkg.sv
package core_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_READ,
        PH_GAP,
        PH_WRITE,
        PH_DONE
    } phase_t;

    // Parity bit that makes the byte plus itself contain an odd number of ones
    function automatic logic odd_fill(input logic [7:0] b);
        return ~(^b);
    endfunction

endpackage

// File: rtl/cs_phase_fsm.sv
module cs_phase_fsm
    import core_seq_pkg::*;
#(
    parameter int READ_CLKS  = 4,
    parameter int STROBE_AT  = 3,
    parameter int GAP_CLKS   = 1,
    parameter int WRITE_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic accept,
    output logic read_act,
    output logic strobe,
    output logic gap_last,
    output logic write_act,
    output logic done,
    output logic busy
);
    localparam int CNT_W = $clog2(READ_CLKS + GAP_CLKS + WRITE_CLKS + 1);

    phase_t            state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + 1'b1;
        unique case (state_q)
            PH_IDLE: begin
                cnt_d = '0;
                if (start) state_d = PH_READ;
            end
            PH_READ: begin
                if (cnt_q == CNT_W'(READ_CLKS - 1)) begin
                    state_d = PH_GAP;
                    cnt_d   = '0;
                end
            end
            PH_GAP: begin
                if (cnt_q == CNT_W'(GAP_CLKS - 1)) begin
                    state_d = PH_WRITE;
                    cnt_d   = '0;
                end
            end
            PH_WRITE: begin
                if (cnt_q == CNT_W'(WRITE_CLKS - 1)) begin
                    state_d = PH_DONE;
                    cnt_d   = '0;
                end
            end
            PH_DONE: begin
                state_d = PH_IDLE;
                cnt_d   = '0;
            end
            default: begin
                state_d = PH_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        accept    = 1'b0;
        read_act  = 1'b0;
        strobe    = 1'b0;
        gap_last  = 1'b0;
        write_act = 1'b0;
        done      = 1'b0;
        busy      = 1'b1;
        unique case (state_q)
            PH_IDLE: begin
                busy   = 1'b0;
                accept = start;
            end
            PH_READ: begin
                read_act = 1'b1;
                strobe   = (cnt_q == CNT_W'(STROBE_AT - 1));
            end
            PH_GAP:   gap_last  = (cnt_q == CNT_W'(GAP_CLKS - 1));
            PH_WRITE: write_act = 1'b1;
            PH_DONE:  done      = 1'b1;
            default:  busy      = 1'b0;
        endcase
    end

    // R11: done lasts one clock
    a_r11_done_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12: once a cycle runs, busy stays up until done
    a_r12_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

endmodule

// File: rtl/cs_addr_decode.sv
module cs_addr_decode #(
    parameter int ADDR_W = 13,
    parameter int X_W    = 6,
    parameter int SEG_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] addr,
    output logic [X_W-1:0]    x_line,
    output logic [ADDR_W-X_W-1:0] y_line,
    output logic [SEG_W-1:0]  seg
);
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      addr_q <= '0;
        else if (accept) addr_q <= addr;
    end

    assign x_line = addr_q[X_W-1:0];
    assign y_line = addr_q[ADDR_W-1:X_W];
    assign seg    = addr_q[ADDR_W-1:ADDR_W-SEG_W];

    // R2: selects stay fixed while no new start is taken
    a_r2_select_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(addr_q));

endmodule

// File: rtl/cs_data_path.sv
module cs_data_path
    import core_seq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SEGS   = 4,
    localparam int PAR_W  = DATA_W / 8,
    localparam int PLANES = DATA_W + PAR_W,
    localparam int SEG_W  = $clog2(SEGS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   accept,
    input  logic                   store_in,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic [PLANES-1:0]      sense,
    input  logic                   strobe,
    input  logic                   gap_last,
    input  logic                   write_act,
    input  logic [SEG_W-1:0]       seg,
    output logic [PLANES-1:0]      data_reg,
    output logic [PLANES*SEGS-1:0] inhibit,
    output logic                   parity_err
);
    logic              store_q;
    logic [DATA_W-1:0] wdata_q;
    logic [PAR_W-1:0]  par_new;
    logic [PAR_W-1:0]  par_bad;

    for (genvar b = 0; b < PAR_W; b++) begin : g_byte
        assign par_new[b] = odd_fill(wdata_q[b*8 +: 8]);
        assign par_bad[b] = odd_fill(data_reg[b*8 +: 8]) != data_reg[DATA_W + b];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_q    <= 1'b0;
            wdata_q    <= '0;
            data_reg   <= '0;
            parity_err <= 1'b0;
        end else if (accept) begin
            store_q    <= store_in;
            wdata_q    <= wr_data;
            data_reg   <= '0;
            parity_err <= 1'b0;
        end else begin
            if (strobe)
                data_reg <= data_reg | sense;
            if (gap_last) begin
                parity_err <= |par_bad;
                if (store_q)
                    data_reg <= {par_new, wdata_q};
            end
        end
    end

    for (genvar p = 0; p < PLANES; p++) begin : g_plane
        for (genvar s = 0; s < SEGS; s++) begin : g_seg
            assign inhibit[p*SEGS + s] = write_act && !data_reg[p]
                                         && (seg == SEG_W'(s));
        end
    end

    // R10: the flag only moves on a start or at the parity check point
    a_r10_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept && !gap_last) |=> $stable(parity_err));

endmodule

// File: rtl/core_cycle_seq.sv
module core_cycle_seq
    import core_seq_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int DATA_W     = 16,
    parameter int X_W        = 6,
    parameter int SEGS       = 4,
    parameter int READ_CLKS  = 4,
    parameter int STROBE_AT  = 3,
    parameter int GAP_CLKS   = 1,
    parameter int WRITE_CLKS = 4,
    localparam int PLANES = DATA_W + DATA_W / 8,
    localparam int Y_W    = ADDR_W - X_W,
    localparam int SEG_W  = $clog2(SEGS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   cyc_store,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic [PLANES-1:0]      sense,
    output logic [X_W-1:0]         x_line,
    output logic [Y_W-1:0]         y_line,
    output logic                   drive_en,
    output logic                   drive_dir,
    output logic                   sense_strobe,
    output logic [PLANES*SEGS-1:0] inhibit,
    output logic [PLANES-1:0]      data_reg,
    output logic                   parity_err,
    output logic                   busy,
    output logic                   done
);
    logic             accept, read_act, gap_last, write_act;
    logic [SEG_W-1:0] seg;

    cs_phase_fsm #(
        .READ_CLKS (READ_CLKS),
        .STROBE_AT (STROBE_AT),
        .GAP_CLKS  (GAP_CLKS),
        .WRITE_CLKS(WRITE_CLKS)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .accept   (accept),
        .read_act (read_act),
        .strobe   (sense_strobe),
        .gap_last (gap_last),
        .write_act(write_act),
        .done     (done),
        .busy     (busy)
    );

    cs_addr_decode #(
        .ADDR_W(ADDR_W),
        .X_W   (X_W),
        .SEG_W (SEG_W)
    ) u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .accept(accept),
        .addr  (addr),
        .x_line(x_line),
        .y_line(y_line),
        .seg   (seg)
    );

    cs_data_path #(
        .DATA_W(DATA_W),
        .SEGS  (SEGS)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .store_in  (cyc_store),
        .wr_data   (wr_data),
        .sense     (sense),
        .strobe    (sense_strobe),
        .gap_last  (gap_last),
        .write_act (write_act),
        .seg       (seg),
        .data_reg  (data_reg),
        .inhibit   (inhibit),
        .parity_err(parity_err)
    );

    assign drive_en  = read_act | write_act;
    assign drive_dir = write_act;

    // R3: an accepted start leads straight into drive toward zero
    a_r3_read_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (drive_en && !drive_dir));

    // R4: the strobe falls only inside the read drive
    a_r4_strobe_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        sense_strobe |-> (drive_en && !drive_dir));

    // R7: inhibit only while driving toward one
    a_r7_inhibit_in_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        !(drive_en && drive_dir) |-> (inhibit == '0));

    // R5: the read drive is followed by a clock without drive
    a_r5_gap_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_en && !drive_dir && !sense_strobe && $past(sense_strobe)) |=> !drive_en);

endmodule

// File: tb/tb_core_cycle_seq.sv
module tb_core_cycle_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        cyc_store = 1'b0;
    logic [12:0] addr = '0;
    logic [15:0] wr_data = '0;
    logic [17:0] sense = '0;
    logic [5:0]  x_line;
    logic [6:0]  y_line;
    logic        drive_en, drive_dir, sense_strobe;
    logic [71:0] inhibit;
    logic [17:0] data_reg;
    logic        parity_err, busy, done;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;  // 50 MHz

    core_cycle_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cyc_store(cyc_store),
        .addr(addr), .wr_data(wr_data), .sense(sense),
        .x_line(x_line), .y_line(y_line), .drive_en(drive_en),
        .drive_dir(drive_dir), .sense_strobe(sense_strobe),
        .inhibit(inhibit), .data_reg(data_reg), .parity_err(parity_err),
        .busy(busy), .done(done)
    );

    // behavioural core array
    logic [17:0] cores [int];
    logic [17:0] shadow [int];

    function automatic logic [17:0] core_rd(input int a);
        return cores.exists(a) ? cores[a] : 18'h0;
    endfunction

    function automatic logic [17:0] shadow_rd(input int a);
        return shadow.exists(a) ? shadow[a] : 18'h0;
    endfunction

    function automatic logic odd_bit(input logic [7:0] b);
        int ones = 0;
        for (int i = 0; i < 8; i++) ones += int'(b[i]);
        return (ones % 2) == 0;
    endfunction

    function automatic logic [17:0] with_par(input logic [15:0] d);
        return {odd_bit(d[15:8]), odd_bit(d[7:0]), d};
    endfunction

    function automatic logic bad_par(input logic [17:0] w);
        return (odd_bit(w[7:0]) != w[16]) || (odd_bit(w[15:8]) != w[17]);
    endfunction

    always @(negedge clk) begin
        int a;
        logic [17:0] w;
        a = int'({y_line, x_line});
        if (drive_en && !drive_dir) sense <= core_rd(a);
        else                        sense <= '0;
        if (drive_en && drive_dir) begin
            for (int p = 0; p < 18; p++) w[p] = !inhibit[p*4 + int'(a[12:11])];
            cores[a] = w;
        end
    end

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one full cycle with per-clock timing checks
    task automatic run_cycle(input logic st, input logic [12:0] a,
                             input logic [15:0] d, input bit poke);
        int bad_r3 = 0, bad_r4 = 0, bad_r5 = 0, bad_r6 = 0, bad_r7 = 0;
        int bad_r2 = 0, bad_r11 = 0, bad_r12 = 0;
        @(negedge clk);
        start = 1'b1; cyc_store = st; addr = a; wr_data = d;
        @(negedge clk);
        start = 1'b0;
        check(parity_err == 1'b0, "R10 cleared at start", 32'(parity_err), 0);
        for (int n = 1; n <= 11; n++) begin
            if (n > 1) @(negedge clk);
            if (n <= 10 && (x_line != a[5:0] || y_line != a[12:6])) bad_r2++;
            if (n <= 4 && !(drive_en && !drive_dir)) bad_r3++;
            if (sense_strobe != (n == 3)) bad_r4++;
            if (n == 5 && drive_en) bad_r5++;
            if (n >= 6 && n <= 9) begin
                if (!(drive_en && drive_dir)) bad_r6++;
                for (int p = 0; p < 18; p++)
                    for (int s = 0; s < 4; s++)
                        if (inhibit[p*4+s] != ((s == int'(a[12:11])) && !data_reg[p]))
                            bad_r6++;
            end else if (inhibit != '0) bad_r7++;
            if (done != (n == 10)) bad_r11++;
            if (n == 11 && (drive_en || busy)) bad_r12++;
            if (poke && n == 2) begin start = 1'b1; addr = a ^ 13'h1ABC; cyc_store = ~st; end
            if (poke && n == 3) start = 1'b0;
        end
        check(bad_r2 == 0, "R2 line selects", bad_r2, 0);
        check(bad_r3 == 0, "R3 read drive", bad_r3, 0);
        check(bad_r4 == 0, "R4 strobe timing", bad_r4, 0);
        check(bad_r5 == 0, "R5 gap clock", bad_r5, 0);
        check(bad_r6 == 0, "R6 write drive and inhibit", bad_r6, 0);
        check(bad_r7 == 0, "R7 inhibit outside write", bad_r7, 0);
        check(bad_r11 == 0, "R11 done pulse", bad_r11, 0);
        if (poke) check(bad_r12 == 0, "R12 start while busy", bad_r12, 0);
    endtask

    // {store, addr, data}
    localparam logic [29:0] VEC [11] = '{
        {1'b1, 13'h0005, 16'h00A5},
        {1'b0, 13'h0005, 16'h0000},
        {1'b1, 13'h0845, 16'h1234},
        {1'b1, 13'h1FFF, 16'hFFFF},
        {1'b0, 13'h1FFF, 16'h0000},
        {1'b0, 13'h0845, 16'h0000},
        {1'b1, 13'h1005, 16'h0000},
        {1'b0, 13'h0005, 16'h0000},
        {1'b0, 13'h1005, 16'h0000},
        {1'b1, 13'h0005, 16'h8001},
        {1'b0, 13'h0005, 16'h0000}
    };

    initial begin
        logic [17:0] prev, exp;
        repeat (3) @(negedge clk);
        check(drive_en == 0 && sense_strobe == 0 && inhibit == '0 && done == 0
              && busy == 0 && data_reg == '0 && parity_err == 0,
              "R1 reset state", {drive_en, busy, done, parity_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0 && drive_en == 0, "R1 idle after reset", {busy, drive_en}, 0);

        foreach (VEC[i]) begin
            logic        st;
            logic [12:0] a;
            logic [15:0] d;
            {st, a, d} = VEC[i];
            prev = shadow_rd(int'(a));
            exp  = st ? with_par(d) : prev;
            run_cycle(st, a, d, 1'b0);
            shadow[int'(a)] = exp;
            check(data_reg == exp, st ? "R9 store word" : "R8 display word",
                  32'(data_reg), 32'(exp));
            check(parity_err == bad_par(prev), "R10 parity flag",
                  32'(parity_err), 32'(bad_par(prev)));
            check(core_rd(int'(a)) == exp, "R6 restored core", 32'(core_rd(int'(a))), 32'(exp));
        end

        // corrupt one core bit: display flags it and restores it unchanged
        cores[32'h0845] = core_rd(32'h0845) ^ 18'h00008;
        exp = shadow_rd(32'h0845) ^ 18'h00008;
        run_cycle(1'b0, 13'h0845, 16'h0, 1'b0);
        check(parity_err == 1'b1, "R10 corrupted word flagged", 32'(parity_err), 1);
        check(data_reg == exp, "R4 sensed corrupted word", 32'(data_reg), 32'(exp));
        repeat (3) @(negedge clk);
        check(parity_err == 1'b1, "R10 flag holds", 32'(parity_err), 1);
        run_cycle(1'b0, 13'h0845, 16'h0, 1'b0);
        check(data_reg == exp, "R8 bad word kept", 32'(data_reg), 32'(exp));
        check(parity_err == 1'b1, "R10 still flagged", 32'(parity_err), 1);

        // store over the bad word: check and load in the same clock
        run_cycle(1'b1, 13'h0845, 16'h5A0F, 1'b0);
        check(parity_err == 1'b1, "R10 check of old word on store", 32'(parity_err), 1);
        check(data_reg == with_par(16'h5A0F), "R9 new word loaded",
              32'(data_reg), 32'(with_par(16'h5A0F)));
        shadow[32'h0845] = with_par(16'h5A0F);

        // start raised while busy
        run_cycle(1'b0, 13'h0845, 16'h0, 1'b1);
        check(data_reg == with_par(16'h5A0F), "R12 cycle unchanged",
              32'(data_reg), 32'(with_par(16'h5A0F)));
        check(core_rd(32'h0845 ^ 32'h1ABC) == 18'h0, "R12 poke address untouched",
              32'(core_rd(32'h0845 ^ 32'h1ABC)), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule